// File: doc/BRIEF.md
# Dual-Channel DAC Serial Load Interface

This block is the digital front end of a two-channel DAC. A host writes it over a three-wire link made of an active-low chip select, a serial clock and a data line. Each 16-bit frame carries four header bits and a 12-bit code. The block keeps one code register per channel. It also keeps one shared shutdown state, which puts both channel outputs and the bias output into high impedance.

The frame takes effect on the rising clock edge that delivers its sixteenth bit. Chip select does not need to rise first. After that edge the block ignores the link until chip select has gone high and fallen again. A frame with the reserved header bit set is dropped and gives a one-cycle error flag. A shutdown can only be released by a frame whose address bit matches the address bit of the frame that entered shutdown.

Top module: `dac_serial_load`

## Requirements
- R1: While `rst_n` is low, both code outputs read zero and `hiz_en` and `frame_err` are low.
- R2: `sdi` is sampled on rising `sclk` edges, most significant bit first. Frame bit 15 is the channel address (0 = channel A, 1 = channel B). Bits 11..0 are the code, with bit 11 as its MSB. A normal frame loads the code into the addressed register only.
- R3: The frame takes effect on the 16th rising edge after `cs_n` falls, and the outputs show it right after that edge while `cs_n` is still low.
- R4: Rising edges that arrive after the 16th within the same low period of `cs_n` change nothing.
- R5: If `cs_n` rises before 16 bits have arrived, the partial frame is dropped and no output changes.
- R6: Frame bit 14 has no effect on any output.
- R7: A frame with bit 13 (shutdown) set raises `hiz_en`, records its address bit and leaves both code registers unchanged.
- R8: A frame with bit 13 clear whose address equals the recorded shutdown address loads its code and lowers `hiz_en`.
- R9: During shutdown, a frame with bit 13 clear and a different address loads its code and leaves `hiz_en` high.
- R10: A frame with bit 12 (reserved, must be 0) set changes no code register and no shutdown state. `frame_err` is high for exactly the one clock cycle after its 16th edge.
- R11: Each new falling edge of `cs_n` starts a fresh frame, after either a complete frame or a dropped partial one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; data is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; high clears the frame state |
| sdi | input | 1 | Serial data, MSB first |
| code_a | output | DATA_W | Code register of channel A |
| code_b | output | DATA_W | Code register of channel B |
| hiz_en | output | 1 | High-impedance enable for both outputs and the bias output |
| frame_err | output | 1 | One-cycle flag for a frame with the reserved bit set |

## Verification
The assertions assume that `cs_n` and `sdi` change only away from rising `sclk` edges. The stimulus meets this by driving both inputs on falling edges. The assertions also assume that two rejected frames can never arrive on consecutive edges, because a frame needs sixteen edges. The bench keeps `rst_n` changes on falling edges as well, and it starts comparing against its model only after reset has been released.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
   // Header sits above the code field, listed from the top bit down
   localparam int HDR_W    = 4;
   localparam int ADDR_OFS = 3;   // channel select
   localparam int FREE_OFS = 2;   // no effect
   localparam int SD_OFS   = 1;   // shutdown request
   localparam int RSV_OFS  = 0;   // must be zero
   localparam int NUM_CH   = 2;

   typedef struct packed {
      logic addr;
      logic sd;
      logic rsv;
   } hdr_t;
endpackage

// File: rtl/dsl_shifter.sv
module dsl_shifter #(
   parameter int FRAME_W = 16
) (
   input  logic               sclk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               sdi,
   output logic               commit,
   output logic               frame_done,
   output logic [FRAME_W-1:0] word
);
   localparam int CNT_W = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   logic [FRAME_W-2:0] sh_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               done_q;
   logic               take;

   assign take       = !cs_n && !done_q;
   assign commit     = take && (cnt_q == LAST);
   assign word       = {sh_q, sdi};
   assign frame_done = done_q;

   // A high chip select clears the frame position at once
   always_ff @(posedge sclk or negedge rst_n or posedge cs_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (cs_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (take) begin
         if (cnt_q == LAST) begin
            done_q <= 1'b1;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)    sh_q <= '0;
      else if (take) sh_q <= word[FRAME_W-2:0];
   end
endmodule

// File: rtl/dsl_decode.sv
module dsl_decode #(
   parameter int DATA_W    = 12,
   parameter bit RSV_CHECK = 1'b1
) (
   input  logic [DATA_W+dsl_pkg::HDR_W-1:0] word,
   input  logic                             commit,
   output dsl_pkg::hdr_t                    hdr,
   output logic [DATA_W-1:0]                data,
   output logic                             accept,
   output logic                             reject
);
   localparam int H0 = DATA_W;

   logic bad;

   assign hdr.addr = word[H0 + dsl_pkg::ADDR_OFS];
   assign hdr.sd   = word[H0 + dsl_pkg::SD_OFS];
   assign hdr.rsv  = word[H0 + dsl_pkg::RSV_OFS];
   assign data     = word[DATA_W-1:0];

   generate
      if (RSV_CHECK) begin : g_rsv_on
         assign bad = hdr.rsv;
      end else begin : g_rsv_off
         assign bad = 1'b0;
      end
   endgenerate

   assign accept = commit && !bad;
   assign reject = commit && bad;
endmodule

// File: rtl/dsl_chan_bank.sv
module dsl_chan_bank #(
   parameter int DATA_W = 12
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              addr,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] codes [dsl_pkg::NUM_CH]
);
   for (genvar ch = 0; ch < dsl_pkg::NUM_CH; ch++) begin : g_ch
      logic hit;
      assign hit = load && (addr == 1'(ch));
      always_ff @(posedge sclk or negedge rst_n) begin
         if (!rst_n)   codes[ch] <= '0;
         else if (hit) codes[ch] <= data;
      end
   end
endmodule

// File: rtl/dsl_pwr.sv
module dsl_pwr (
   input  logic sclk,
   input  logic rst_n,
   input  logic accept,
   input  logic addr,
   input  logic sd,
   output logic hiz_en
);
   logic off_q;
   logic key_q;

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= 1'b0;
         key_q <= 1'b0;
      end else if (accept) begin
         if (sd) begin
            off_q <= 1'b1;
            key_q <= addr;
         end else if (off_q && (addr == key_q)) begin
            off_q <= 1'b0;
         end
      end
   end

   assign hiz_en = off_q;
endmodule

// File: rtl/dac_serial_load.sv
module dac_serial_load #(
   parameter int DATA_W    = 12,
   parameter bit RSV_CHECK = 1'b1
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sdi,
   output logic [DATA_W-1:0] code_a,
   output logic [DATA_W-1:0] code_b,
   output logic              hiz_en,
   output logic              frame_err
);
   localparam int FRAME_W = DATA_W + dsl_pkg::HDR_W;

   if (DATA_W < 2 || DATA_W > 28) begin : g_bad_width
      $error("dac_serial_load: DATA_W out of range");
   end

   logic                commit;
   logic                frame_done;
   logic [FRAME_W-1:0]  word;
   dsl_pkg::hdr_t       hdr;
   logic [DATA_W-1:0]   data;
   logic                accept;
   logic                reject;
   logic [DATA_W-1:0]   codes [dsl_pkg::NUM_CH];
   logic                err_q;

   dsl_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
      .commit(commit), .frame_done(frame_done), .word(word)
   );

   dsl_decode #(.DATA_W(DATA_W), .RSV_CHECK(RSV_CHECK)) u_dec (
      .word(word), .commit(commit), .hdr(hdr), .data(data),
      .accept(accept), .reject(reject)
   );

   dsl_chan_bank #(.DATA_W(DATA_W)) u_bank (
      .sclk(sclk), .rst_n(rst_n), .load(accept && !hdr.sd),
      .addr(hdr.addr), .data(data), .codes(codes)
   );

   dsl_pwr u_pwr (
      .sclk(sclk), .rst_n(rst_n), .accept(accept),
      .addr(hdr.addr), .sd(hdr.sd), .hiz_en(hiz_en)
   );

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= reject;
   end

   assign code_a    = codes[0];
   assign code_b    = codes[1];
   assign frame_err = err_q;
endmodule

// File: rtl/dsl_chk.sv
module dsl_chk #(
   parameter int DATA_W = 12
) (
   input logic              sclk,
   input logic              rst_n,
   input logic              cs_n,
   input logic [DATA_W-1:0] code_a,
   input logic [DATA_W-1:0] code_b,
   input logic              hiz_en,
   input logic              frame_err,
   input logic              frame_done
);
   AST_CS_HIGH_HOLDS: assert property (@(posedge sclk) disable iff (!rst_n)
      cs_n |=> ($stable(code_a) && $stable(code_b) && $stable(hiz_en))); // R5

   AST_AFTER_DONE_HOLDS: assert property (@(posedge sclk) disable iff (!rst_n)
      (frame_done && !cs_n) |=> ($stable(code_a) && $stable(code_b) && $stable(hiz_en))); // R4

   AST_ERR_SINGLE: assert property (@(posedge sclk) disable iff (!rst_n)
      frame_err |=> !frame_err); // R10

   AST_ERR_NO_EFFECT: assert property (@(posedge sclk) disable iff (!rst_n)
      (frame_err && $past(rst_n)) |-> ($stable(code_a) && $stable(code_b) && $stable(hiz_en))); // R10

   AST_ONE_CHANNEL: assert property (@(posedge sclk) disable iff (!rst_n)
      !(!$stable(code_a) && !$stable(code_b))); // R2

   AST_SD_KEEPS_CODES: assert property (@(posedge sclk) disable iff (!rst_n)
      ($rose(hiz_en) && $past(rst_n)) |-> ($stable(code_a) && $stable(code_b))); // R7
endmodule

bind dac_serial_load dsl_chk #(.DATA_W(DATA_W)) u_chk (
   .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .code_a(code_a), .code_b(code_b),
   .hiz_en(hiz_en), .frame_err(frame_err), .frame_done(frame_done)
);

// File: tb/sim_dac_serial_load.sv
module sim_dac_serial_load;
   localparam time CLK_PERIOD = 10ns;

   logic        sclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sdi = 1'b0;
   logic [11:0] code_a, code_b;
   logic        hiz_en, frame_err;

   int total = 0;
   int bad = 0;
   bit cmp_on = 1'b0;

   // reference model state
   int m_cnt = 0, m_done = 0, m_word = 0;
   int m_a = 0, m_b = 0, m_hz = 0, m_key = 0, m_err = 0;

   dac_serial_load u0 (
      .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
      .code_a(code_a), .code_b(code_b), .hiz_en(hiz_en), .frame_err(frame_err)
   );

   always #(CLK_PERIOD/2) sclk = ~sclk;

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural model of the frame rules
   always @(posedge sclk) begin
      if (!rst_n) begin
         m_cnt = 0; m_done = 0; m_word = 0;
         m_a = 0; m_b = 0; m_hz = 0; m_key = 0; m_err = 0;
      end else if (cs_n) begin
         m_cnt = 0; m_done = 0; m_err = 0;
      end else if (m_done == 0) begin
         m_word = ((m_word << 1) | int'(sdi)) & 16'hFFFF;
         m_cnt++;
         m_err = 0;
         if (m_cnt == 16) begin
            m_done = 1;
            if ((m_word >> 12) & 1) m_err = 1;
            else if ((m_word >> 13) & 1) begin
               m_hz = 1;
               m_key = (m_word >> 15) & 1;
            end else begin
               if ((m_word >> 15) & 1) m_b = m_word & 12'hFFF;
               else                    m_a = m_word & 12'hFFF;
               if (m_hz == 1 && ((m_word >> 15) & 1) == m_key) m_hz = 0;
            end
         end
      end else begin
         m_err = 0;
      end
   end

   always @(negedge sclk) begin
      if (cmp_on) begin
         check("R2 model code_a", int'(code_a), m_a);
         check("R2 model code_b", int'(code_b), m_b);
         check("R7 model hiz_en", int'(hiz_en), m_hz);
         check("R10 model frame_err", int'(frame_err), m_err);
      end
   end

   // drive n bits of w MSB first; returns at the falling edge after the last bit
   task automatic shift_bits(input logic [15:0] w, input int n);
      for (int i = 15; i > 15 - n; i--) begin
         @(negedge sclk);
         cs_n = 1'b0;
         sdi  = w[i];
      end
      @(negedge sclk);
   endtask

   task automatic end_frame();
      cs_n = 1'b1;
      sdi  = 1'b0;
      @(negedge sclk);
      @(negedge sclk);
   endtask

   function automatic logic [15:0] mk(input bit a, input bit x, input bit sd,
                                      input bit rsv, input logic [11:0] d);
      return {a, x, sd, rsv, d};
   endfunction

   initial begin
      repeat (3) @(negedge sclk);
      check("R1 code_a", int'(code_a), 0);
      check("R1 code_b", int'(code_b), 0);
      check("R1 hiz_en", int'(hiz_en), 0);
      check("R1 frame_err", int'(frame_err), 0);
      rst_n = 1'b1;
      @(negedge sclk);
      cmp_on = 1'b1;

      // R2 R3: channel A load, seen while cs_n still low
      shift_bits(mk(0, 0, 0, 0, 12'hABC), 16);
      check("R3 code_a before cs rise", int'(code_a), 'hABC);
      check("R2 code_b untouched", int'(code_b), 0);
      end_frame();

      // R6: don't-care bit set, channel B
      shift_bits(mk(1, 1, 0, 0, 12'h123), 16);
      check("R6 code_b", int'(code_b), 'h123);
      check("R2 code_a kept", int'(code_a), 'hABC);
      end_frame();

      // R4: extra edges in the same low period
      shift_bits(mk(0, 0, 0, 0, 12'h555), 16);
      sdi = 1'b1;
      repeat (20) @(negedge sclk);
      check("R4 code_a after extra edges", int'(code_a), 'h555);
      check("R4 hiz_en after extra edges", int'(hiz_en), 0);
      end_frame();

      // R5: partial frame dropped
      shift_bits(mk(0, 0, 1, 0, 12'hFFF), 10);
      end_frame();
      check("R5 code_a", int'(code_a), 'h555);
      check("R5 hiz_en", int'(hiz_en), 0);

      // R11: fresh frame right after a dropped one
      shift_bits(mk(0, 0, 0, 0, 12'h0F0), 16);
      check("R11 code_a", int'(code_a), 'h0F0);
      end_frame();

      // R7: shutdown entered from address 1
      shift_bits(mk(1, 0, 1, 0, 12'hFFF), 16);
      check("R7 hiz_en", int'(hiz_en), 1);
      check("R7 code_b kept", int'(code_b), 'h123);
      end_frame();

      // R9: mismatched address loads but stays in shutdown
      shift_bits(mk(0, 0, 0, 0, 12'h321), 16);
      check("R9 code_a", int'(code_a), 'h321);
      check("R9 hiz_en", int'(hiz_en), 1);
      end_frame();

      // R8: matching address releases
      shift_bits(mk(1, 0, 0, 0, 12'h777), 16);
      check("R8 code_b", int'(code_b), 'h777);
      check("R8 hiz_en", int'(hiz_en), 0);
      end_frame();

      // R10: reserved bit set
      shift_bits(mk(0, 0, 1, 1, 12'h000), 16);
      check("R10 frame_err", int'(frame_err), 1);
      check("R10 code_a", int'(code_a), 'h321);
      check("R10 hiz_en", int'(hiz_en), 0);
      @(negedge sclk);
      check("R10 frame_err one cycle", int'(frame_err), 0);
      end_frame();

      // R2: MSB-first with an asymmetric pattern
      shift_bits(mk(0, 0, 0, 0, 12'h801), 16);
      check("R2 code_a msb first", int'(code_a), 'h801);
      end_frame();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge sclk);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule